// File: doc/BRIEF.md
# Source Gather Address Generator

This block produces the source-side read addresses for one DMA channel that collects data from memory in separated runs. A run is a group of transfers at adjacent addresses; after each run the address skips a gap and the next run begins. The run length and the gap size are both programmed. The gap is given in units of the transfer size. The words from all runs are read in rising address order, so they can leave the channel as one continuous stream.

Software supplies a base address, a transfer-width code, a run length, a gap length and a total transfer count, then pulses start. The block presents one address at a time with a valid flag. The data path pulses an advance strobe once it has consumed that address. The block flags the final transfer of each run. After the advance that completes the total, it raises done. It then produces nothing further until the next start pulse.

Top module: `gather_addr_gen`

## Requirements
- R1: On the cycle after a start pulse with a nonzero total, `valid_o` is 1, `done_o` is 0 and `addr_o` equals the base address sampled with the start pulse.
- R2: The width code sets the byte step: 3'b000 gives 1 byte, 3'b001 gives 2 bytes, 3'b010 gives 4 bytes, and every other code gives 4 bytes.
- R3: Inside a run, each accepted advance raises `addr_o` by exactly one step.
- R4: An accepted advance on the last transfer of a run raises `addr_o` by the step multiplied by (gap length + 1). The run counter then restarts, so every run, including the first, holds exactly the run length in transfers.
- R5: A run length of zero disables gathering. Every advance then moves by one step, and `run_last_o` stays 0.
- R6: `run_last_o` is 1 exactly while the presented address is transfer number L-1, 2L-1, 3L-1 and so on (counting from 0) of the session, where L is a nonzero run length.
- R7: The advance that completes the total clears `valid_o` and sets `done_o` on the next cycle. `done_o` holds until the next start, and `valid_o` and `done_o` are never both 1.
- R8: An advance strobe while `valid_o` is 0 has no effect. `addr_o`, `valid_o` and `done_o` stay unchanged.
- R9: A start pulse with a total of zero raises `done_o` on the next cycle and never raises `valid_o`.
- R10: A start pulse during an unfinished session abandons that session and begins a new one with the new settings, as in R1.
- R11: While reset is held, `addr_o` is 0 and `valid_o`, `run_last_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a session; samples all settings |
| base_addr_i | input | ADDR_W | First read address |
| width_i | input | 3 | Transfer-width code |
| run_len_i | input | CNT_W | Transfers per run; 0 disables gathering |
| gap_len_i | input | GAP_W | Gap between runs, in transfer-size units |
| total_i | input | TOT_W | Transfers in the session |
| advance_i | input | 1 | Current address consumed |
| addr_o | output | ADDR_W | Current read address |
| valid_o | output | 1 | `addr_o` is a live address |
| run_last_o | output | 1 | Current transfer closes a run |
| done_o | output | 1 | Session complete |

## Verification
The bench uses the default parameters: a 32-bit address, a 6-bit run length, an 8-bit gap and an 8-bit total. Sessions of up to 255 transfers therefore cross dozens of run boundaries. Random run lengths of 0 to 5 and gaps of 0 to 4 mix short runs, zero gaps and disabled gathering under every width code, including the codes that fall back to 4 bytes. Directed cases add a total of zero, a run length of one, and a restart in the middle of a session.

// File: rtl/gather_pkg.sv
// Shared definitions for the gather address generator.
// Assumes width codes are 3 bits; codes above 3'b010 fall back to 32 bits.
package gather_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_shift_e;

    // Map a width code to log2 of the transfer size in bytes.
    function automatic size_shift_e width_to_shift(input logic [2:0] code);
        case (code)
            3'b000:  return SZ_BYTE;
            3'b001:  return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

endpackage

// File: rtl/gather_step_sel.sv
// Address increment selector.
// Produces the byte increment for one advance: one transfer size, or one
// transfer size plus the gap when the current transfer closes a run.
// Assumes ADDR_W exceeds GAP_W + 3 so the scaled gap cannot overflow.
module gather_step_sel
    import gather_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GAP_W  = 8
) (
    input  size_shift_e         shift_i,
    input  logic [GAP_W-1:0]    gap_i,
    input  logic                boundary_i,
    output logic [ADDR_W-1:0]   incr_o
);
    localparam int PAD_W = ADDR_W - GAP_W;

    logic [ADDR_W-1:0] unit_bytes;
    logic [ADDR_W-1:0] gap_bytes;

    // Scale one unit and the gap by the transfer size, then sum on a boundary.
    always_comb begin
        unit_bytes = ADDR_W'(1) << shift_i;
        gap_bytes  = {{PAD_W{1'b0}}, gap_i} << shift_i;
        incr_o     = boundary_i ? (unit_bytes + gap_bytes) : unit_bytes;
    end

endmodule

// File: rtl/gather_run_ctr.sv
// Run position counter.
// Counts transfers within the current run and flags the last one.
// Assumes run_len_i is stable for a session; zero means no runs.
module gather_run_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] run_len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] pos_q;
    logic             enabled;

    // Decode whether gathering is active and the position closes a run.
    always_comb begin
        enabled = (run_len_i != '0);
        last_o  = enabled && (pos_q == run_len_i - CNT_W'(1));
    end

    // Advance the position, wrapping to zero after the last transfer of a run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pos_q <= '0;
        end else if (step_i && enabled) begin
            pos_q <= last_o ? '0 : pos_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/gather_xfer_ctr.sv
// Session transfer counter.
// Counts accepted transfers and flags the one that completes the total.
// Assumes total_i is nonzero whenever step_i is raised.
module gather_xfer_ctr #(
    parameter int TOT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [TOT_W-1:0] total_i,
    output logic             final_o
);
    logic [TOT_W-1:0] seen_q;

    // Flag the transfer whose acceptance reaches the total.
    always_comb final_o = (seen_q == total_i - TOT_W'(1));

    // Count accepted transfers since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            seen_q <= '0;
        end else if (step_i) begin
            seen_q <= seen_q + TOT_W'(1);
        end
    end

endmodule

// File: rtl/gather_addr_gen.sv
// Source gather address generator, top level.
// Presents one read address at a time, stepping by the transfer size and
// jumping over a programmed gap after each run. All settings are sampled on
// start_i; start has priority over advance. Synchronous active-low reset.
module gather_addr_gen
    import gather_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 6,
    parameter int GAP_W  = 8,
    parameter int TOT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [2:0]        width_i,
    input  logic [CNT_W-1:0]  run_len_i,
    input  logic [GAP_W-1:0]  gap_len_i,
    input  logic [TOT_W-1:0]  total_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              run_last_o,
    output logic              done_o
);
    size_shift_e       shift_q;
    logic [CNT_W-1:0]  run_len_q;
    logic [GAP_W-1:0]  gap_q;
    logic [TOT_W-1:0]  total_q;
    logic [ADDR_W-1:0] addr_q;
    logic              valid_q;
    logic              done_q;
    logic              take;
    logic              boundary;
    logic              final_xfer;
    logic [ADDR_W-1:0] incr;

    // An advance counts only while an address is live and no restart is pending.
    always_comb take = valid_q && advance_i && !start_i;

    gather_run_ctr #(.CNT_W(CNT_W)) i_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .step_i    (take),
        .run_len_i (run_len_q),
        .last_o    (boundary)
    );

    gather_xfer_ctr #(.TOT_W(TOT_W)) i_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (take),
        .total_i (total_q),
        .final_o (final_xfer)
    );

    gather_step_sel #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) i_step (
        .shift_i    (shift_q),
        .gap_i      (gap_q),
        .boundary_i (boundary),
        .incr_o     (incr)
    );

    // Sample the session settings on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= SZ_BYTE;
            run_len_q <= '0;
            gap_q     <= '0;
            total_q   <= '0;
        end else if (start_i) begin
            shift_q   <= width_to_shift(width_i);
            run_len_q <= run_len_i;
            gap_q     <= gap_len_i;
            total_q   <= total_i;
        end
    end

    // Hold the live address and the session state flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (start_i) begin
            addr_q  <= base_addr_i;
            valid_q <= (total_i != '0);
            done_q  <= (total_i == '0);
        end else if (take) begin
            if (final_xfer) begin
                valid_q <= 1'b0;
                done_q  <= 1'b1;
            end else begin
                addr_q <= addr_q + incr;
            end
        end
    end

    // Drive the outputs from the held state.
    always_comb begin
        addr_o     = addr_q;
        valid_o    = valid_q;
        done_o     = done_q;
        run_last_o = valid_q && boundary;
    end

endmodule

// File: rtl/gather_addr_chk.sv
// Property checker for the gather address generator, bound to the top.
// Observes ports only and relates them across clock edges.
module gather_addr_chk #(
    parameter int ADDR_W = 32,
    parameter int TOT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic [TOT_W-1:0]  total_i,
    input logic              advance_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              valid_o,
    input logic              run_last_o,
    input logic              done_o
);
    assert_start_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (total_i != '0) |=> valid_o && !done_o && (addr_o == $past(base_addr_i)));

    assert_advance_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && advance_i && !start_i |=> !valid_o || (addr_o != $past(addr_o)));

    assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_last_o |-> valid_o);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && done_o));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);

    assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && !start_i |=> $stable(addr_o) && !valid_o);

    assert_empty_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (total_i == '0) |=> done_o && !valid_o);

endmodule

bind gather_addr_gen gather_addr_chk #(.ADDR_W(ADDR_W), .TOT_W(TOT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .total_i     (total_i),
    .advance_i   (advance_i),
    .addr_o      (addr_o),
    .valid_o     (valid_o),
    .run_last_o  (run_last_o),
    .done_o      (done_o)
);

// File: tb/test_gather_addr_gen.sv
// Self-checking bench: random sessions plus directed corners, compared at
// the falling edge against an address model computed by bench functions.
module test_gather_addr_gen;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 6;
    localparam int GAP_W  = 8;
    localparam int TOT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [2:0]        width_i = '0;
    logic [CNT_W-1:0]  run_len_i = '0;
    logic [GAP_W-1:0]  gap_len_i = '0;
    logic [TOT_W-1:0]  total_i = '0;
    logic              advance_i = 1'b0;
    logic [ADDR_W-1:0] addr_o;
    logic              valid_o;
    logic              run_last_o;
    logic              done_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    gather_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .GAP_W(GAP_W), .TOT_W(TOT_W))
    i_gather_addr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .width_i(width_i), .run_len_i(run_len_i), .gap_len_i(gap_len_i),
        .total_i(total_i), .advance_i(advance_i), .addr_o(addr_o),
        .valid_o(valid_o), .run_last_o(run_last_o), .done_o(done_o)
    );

    function automatic int size_shift(input logic [2:0] w);
        return (w == 3'b000) ? 0 : (w == 3'b001) ? 1 : 2;
    endfunction

    function automatic logic [31:0] model_addr(input logic [31:0] b, input logic [2:0] w,
                                               input int c, input int g, input int k);
        int sh = size_shift(w);
        logic [31:0] a = b + 32'(k << sh);
        if (c != 0) a = a + 32'((k / c) * (g << sh));
        return a;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One session; cut >= 0 abandons it after that many cycles (restart test).
    task automatic session(input logic [31:0] b, input logic [2:0] w, input int c,
                           input int g, input int tot, input int cut, input int adv_pct);
        int  k = 0;
        bit  active = (tot != 0);
        int  idle = 0;
        string areq;
        areq = (c == 0) ? "R2 R3 R5" : "R2 R3 R4";
        @(negedge clk);
        start_i = 1'b1; advance_i = 1'b0;
        base_addr_i = b; width_i = w; run_len_i = CNT_W'(c);
        gap_len_i = GAP_W'(g); total_i = TOT_W'(tot);
        @(negedge clk);
        start_i = 1'b0;
        if (tot == 0) begin
            check("R9", "done", 32'(done_o), 32'd1);
            check("R9", "valid", 32'(valid_o), 32'd0);
        end else begin
            check("R1 R10", "first addr", addr_o, b);
            check("R1 R10", "valid", 32'(valid_o), 32'd1);
        end
        for (int cyc = 0; cyc < 2000; cyc++) begin
            int ki = (tot == 0) ? 0 : ((k < tot) ? k : tot - 1);
            bit adv;
            check(areq, "addr", addr_o, model_addr(b, w, c, g, ki));
            check("R7", "valid", 32'(valid_o), 32'(active));
            check("R7", "done", 32'(done_o), 32'(!active));
            check(c == 0 ? "R5" : "R6", "run_last", 32'(run_last_o),
                  32'(active && c != 0 && (k % c) == c - 1));
            if (cut >= 0 && cyc == cut) return;
            if (!active) begin
                if (idle == 3) return;
                idle++;
                adv = 1'b1;                 // R8: strobes after done must be ignored
            end else begin
                adv = ($urandom % 100) < adv_pct;
            end
            advance_i = adv;
            if (adv && active) begin
                k++;
                if (k == tot) active = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stimulus
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R11", "addr", addr_o, 32'd0);
        check("R11", "valid", 32'(valid_o), 32'd0);
        check("R11", "run_last", 32'(run_last_o), 32'd0);
        check("R11", "done", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        // Directed: 32-bit, runs of 4, gap of 1, three runs.
        session(32'h0000_1000, 3'b010, 4, 1, 12, -1, 100);
        // R2: each width code, continuous advance.
        for (int w = 0; w < 8; w++) session(32'h0000_2000, 3'(w), 3, 2, 9, -1, 100);
        // R5: gathering disabled.
        session(32'h0000_3000, 3'b001, 0, 7, 10, -1, 60);
        // R9: empty session.
        session(32'h0000_4000, 3'b010, 2, 1, 0, -1, 100);
        // Run length of one: gap after every transfer.
        session(32'h0000_5000, 3'b000, 1, 3, 8, -1, 100);
        // R10: restart mid-session, then a fresh session.
        session(32'h0000_6000, 3'b010, 3, 1, 30, 7, 100);
        session(32'h0000_7000, 3'b001, 2, 2, 6, -1, 100);
        // Long session crossing many boundaries.
        session(32'h0001_0000, 3'b010, 5, 4, 255, -1, 80);
        // Random sessions.
        for (int s = 0; s < 40; s++) begin
            session({$urandom} & 32'h00FF_FFFC, 3'($urandom % 8), int'($urandom % 6),
                    int'($urandom % 5), 1 + int'($urandom % 40),
                    ($urandom % 8 == 0) ? int'($urandom % 10) : -1, 50 + int'($urandom % 50));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule